// File: doc/BRIEF.md
# Register-Mapped Serial Master Controller

This block is a serial-peripheral master that sits on a simple 32-bit register port. Software programs a mode word, then writes one character of 4 to 32 bits into the transmit location. The block shifts that character out on a serial clock and data line and captures the returning data line in the same pass. When the character is done, it leaves the received character in the receive location and sets a status flag. Software either polls that flag or lets it raise the interrupt.

The mode word holds several settings: enable, master, bit order (most significant bit first or least significant first) and internal loopback. It also holds a 4-bit character-length code and a 4-bit clock prescaler. The serial clock uses mode 0 timing. It idles low, outgoing data changes on the falling edge, and incoming data is sampled on the rising edge. Two status flags, "receive full" and "transmit ready", are cleared by writing one to them. A mask word chooses which flags drive the interrupt output. Chip selects are driven by software elsewhere.

Top module: `sermst_ctrl`

## Requirements
- R1: After reset the mode word reads 0, the status word reads 0x0000_0100 (transmit-ready at bit 8 set, receive-full at bit 9 clear), the receive word reads 0, and the serial clock and interrupt are low.
- R2: The register window is decoded on the byte address: mode at 0x20, status at 0x24, mask at 0x28, command at 0x2C, transmit at 0x30 (write only) and receive at 0x34. The mode word keeps only bits 30, 26, 25, 24 and 23:16, so writing all ones reads back 0x47FF_0000. The mask word reads back as written. Every other address reads 0 and ignores writes.
- R3: A transmit write while enabled (mode bit 24) clears transmit-ready on the write edge. When the shifter is idle, the character is handed over on the next edge, and transmit-ready is set again on that same edge.
- R4: The serial clock idles low. Each half period lasts 4·P system clocks, where P is mode bits 19:16 (P=0 counts as 16), so P=1 gives a clock of the system clock divided by 8.
- R5: The length code in mode bits 23:20 selects 32 bits for code 0, code+1 bits for codes 3 to 15, and 4 bits for codes 1 and 2. Only the low N bits of the transmit word are sent, and the received character sits right-justified in the receive word with zeros above it. Receive-full is set 2 + 2·N·4P edges after the transmit write edge.
- R6: With mode bit 26 set, bits go out and come in most significant bit first. With it clear, the least significant bit goes first.
- R7: With mode bit 30 set, the outgoing data feeds the receiver internally and the external input is ignored, so the received character equals the sent one.
- R8: Writing one to status bit 9 or bit 8 clears that flag, and writing zero leaves it unchanged. A completing character sets receive-full.
- R9: The interrupt output is high exactly when some status flag is set and its mask bit (same bit position) is set. A mask of zero keeps the interrupt low.
- R10: A transmit write while disabled is discarded: no serial clock edge occurs, transmit-ready stays set and receive-full stays clear.
- R11: Writes to the command word have no effect on the mode, status or transfers, and the command word reads 0.
- R12: The outgoing data line changes only on falling serial clock edges and is stable at every rising edge. The incoming bit is taken at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 8 | Byte address inside the 256-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on the address |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| irq_o | output | 1 | Interrupt request |

## Verification
Transmit-ready drops on the transmit write edge and is back one edge later. Receive-full and the receive word change on edge 2 + 2·N·4P counted from the write edge, so the bench checks the flag low one edge before that and high on it. Each observation is taken on the falling system clock after a known number of edges, with reads made half a cycle away from any rising edge. Serial-clock high time is counted on falling system-clock edges and must equal N·4P. Outgoing bits are gathered on rising serial-clock edges, and the bench slave changes its bit on falling ones, so data never races the clock.

// File: rtl/sermst_pkg.sv
package sermst_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BITS_W = 6;

  localparam logic [7:0] OFS_MODE = 8'h20;
  localparam logic [7:0] OFS_EVT  = 8'h24;
  localparam logic [7:0] OFS_MASK = 8'h28;
  localparam logic [7:0] OFS_CMD  = 8'h2C;
  localparam logic [7:0] OFS_TX   = 8'h30;
  localparam logic [7:0] OFS_RX   = 8'h34;

  localparam int unsigned MB_LOOP = 30;
  localparam int unsigned MB_MSB  = 26;
  localparam int unsigned MB_MST  = 25;
  localparam int unsigned MB_EN   = 24;
  localparam int unsigned EB_RNE  = 9;
  localparam int unsigned EB_TNF  = 8;
  localparam logic [31:0] MODE_KEEP = 32'h47FF_0000;

  // Character length in bits from the 4-bit length code.
  function automatic logic [BITS_W-1:0] char_bits(input logic [3:0] code);
    if (code == 4'd0)     return BITS_W'(32);
    else if (code < 4'd3) return BITS_W'(4);
    else                  return BITS_W'(code) + BITS_W'(1);
  endfunction

  // System clocks per serial-clock half period.
  function automatic int unsigned half_cycles(input logic [3:0] pre, input int unsigned unit);
    return ((pre == 4'd0) ? 16 : int'(pre)) * unit;
  endfunction
endpackage

// File: rtl/sermst_clkgen.sv
module sermst_clkgen #(
  parameter int unsigned HALF_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || restart || tick || !run) cnt_q <= '0;
    else                                   cnt_q <= cnt_q + HALF_W'(1);
  end
endmodule

// File: rtl/sermst_shifter.sv
module sermst_shifter
  import sermst_pkg::*;
#(
  parameter int unsigned HALF_UNIT = 4,
  localparam int unsigned HALF_W = $clog2(16 * HALF_UNIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        cfg_len,
  input  logic [3:0]        cfg_pre,
  input  logic              cfg_msb,
  input  logic              cfg_loop,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);
  logic [WORD_W-1:0] tx_sh, rx_sh;
  logic [BITS_W-1:0] nbits_q, left_q, load_bits;
  logic [HALF_W-1:0] half_q;
  logic              msb_q, loop_q, sck_q, busy_q, done_q, tick;
  logic              out_bit, in_bit;

  assign load_bits = char_bits(cfg_len);
  assign out_bit   = msb_q ? tx_sh[WORD_W-1] : tx_sh[0];
  assign in_bit    = loop_q ? out_bit : miso;

  sermst_clkgen #(.HALF_W(HALF_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .restart(start),
    .half(half_q), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh <= '0; rx_sh <= '0; nbits_q <= BITS_W'(32); left_q <= '0;
      half_q <= HALF_W'(HALF_UNIT); msb_q <= 1'b0; loop_q <= 1'b0;
      sck_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        tx_sh   <= cfg_msb ? (tx_word << (BITS_W'(32) - load_bits)) : tx_word;
        rx_sh   <= '0;
        nbits_q <= load_bits;
        left_q  <= load_bits;
        half_q  <= HALF_W'(half_cycles(cfg_pre, HALF_UNIT));
        msb_q   <= cfg_msb;
        loop_q  <= cfg_loop;
        sck_q   <= 1'b0;
        busy_q  <= 1'b1;
      end else if (tick) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_sh <= msb_q ? {rx_sh[WORD_W-2:0], in_bit} : {in_bit, rx_sh[WORD_W-1:1]};
        end else begin
          sck_q  <= 1'b0;
          tx_sh  <= msb_q ? (tx_sh << 1) : (tx_sh >> 1);
          left_q <= left_q - BITS_W'(1);
          if (left_q == BITS_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign sck     = sck_q;
  assign mosi    = busy_q & out_bit;
  assign rx_word = msb_q ? rx_sh : (rx_sh >> (BITS_W'(32) - nbits_q));
endmodule

// File: rtl/sermst_evt.sv
module sermst_evt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       handoff,
  input  logic       done,
  input  logic       clr_we,
  input  logic [1:0] clr_bits,
  input  logic [1:0] mask_bits,
  output logic       tnf,
  output logic       rne,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tnf <= 1'b1;
      rne <= 1'b0;
    end else begin
      if (done)                         rne <= 1'b1;
      else if (clr_we && clr_bits[1])   rne <= 1'b0;
      if (accept)                       tnf <= 1'b0;
      else if (handoff)                 tnf <= 1'b1;
      else if (clr_we && clr_bits[0])   tnf <= 1'b0;
    end
  end

  assign irq = |({rne, tnf} & mask_bits);
endmodule

// File: rtl/sermst_ctrl.sv
module sermst_ctrl
  import sermst_pkg::*;
#(
  parameter int unsigned HALF_UNIT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck_o,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic        irq_o
);
  logic [31:0] mode_q, mask_q, rx_q, txbuf_q, rx_word, ev_word;
  logic        pend_q, wr, tx_wr, tx_ok, start, mode_en;
  logic        eng_busy, eng_done, ev_tnf, ev_rne;

  assign wr      = bus_sel && bus_we;
  assign tx_wr   = wr && (bus_addr == OFS_TX);
  assign mode_en = mode_q[MB_EN];
  assign tx_ok   = tx_wr && mode_en;
  assign start   = pend_q && !eng_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; mask_q <= '0; rx_q <= '0; txbuf_q <= '0; pend_q <= 1'b0;
    end else begin
      if (wr && bus_addr == OFS_MODE) mode_q <= bus_wdata & MODE_KEEP;
      if (wr && bus_addr == OFS_MASK) mask_q <= bus_wdata;
      if (tx_ok) begin
        txbuf_q <= bus_wdata;
        pend_q  <= 1'b1;
      end else if (start) begin
        pend_q  <= 1'b0;
      end
      if (eng_done) rx_q <= rx_word;
    end
  end

  sermst_shifter #(.HALF_UNIT(HALF_UNIT)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_len(mode_q[23:20]), .cfg_pre(mode_q[19:16]),
    .cfg_msb(mode_q[MB_MSB]), .cfg_loop(mode_q[MB_LOOP]),
    .tx_word(txbuf_q), .miso(miso_i),
    .busy(eng_busy), .done(eng_done), .sck(sck_o), .mosi(mosi_o),
    .rx_word(rx_word)
  );

  sermst_evt u_evt (
    .clk(clk), .rst_n(rst_n), .accept(tx_ok), .handoff(start),
    .done(eng_done), .clr_we(wr && bus_addr == OFS_EVT),
    .clr_bits({bus_wdata[EB_RNE], bus_wdata[EB_TNF]}),
    .mask_bits({mask_q[EB_RNE], mask_q[EB_TNF]}),
    .tnf(ev_tnf), .rne(ev_rne), .irq(irq_o)
  );

  always_comb begin
    ev_word = '0;
    ev_word[EB_RNE] = ev_rne;
    ev_word[EB_TNF] = ev_tnf;
  end

  always_comb begin
    case (bus_addr)
      OFS_MODE: bus_rdata = mode_q;
      OFS_EVT:  bus_rdata = ev_word;
      OFS_MASK: bus_rdata = mask_q;
      OFS_RX:   bus_rdata = rx_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sermst_checker.sv
module sermst_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       mosi,
  input logic       irq,
  input logic       busy,
  input logic       done,
  input logic       start,
  input logic       tx_ok,
  input logic       tnf,
  input logic       rne,
  input logic [1:0] mask_ev
);
  a_r3_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ok |=> !tnf);
  a_r3_handoff_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !tx_ok) |=> (tnf && busy));
  a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  a_r8_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rne);
  a_r9_zero_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_ev == 2'b00) |-> !irq);
  a_r12_mosi_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));
endmodule

bind sermst_ctrl sermst_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck_o), .mosi(mosi_o), .irq(irq_o),
  .busy(eng_busy), .done(eng_done), .start(start), .tx_ok(tx_ok),
  .tnf(ev_tnf), .rne(ev_rne), .mask_ev({mask_q[9], mask_q[8]})
);

// File: tb/sermst_ctrl_test.sv
`timescale 1ns/1ps
module sermst_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        sck_o, mosi_o, miso_i, irq_o;
  int          n_run = 0, n_fail = 0;

  // bench slave
  logic [31:0] slv_word = '0;
  int          slv_len = 8, slv_idx = 0;
  logic        slv_msb = 1'b1;
  logic [31:0] cap = '0;
  int          hi_cnt = 0;

  always #2.5 clk = ~clk;

  sermst_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i), .irq_o(irq_o)
  );

  assign miso_i = (slv_idx >= slv_len) ? 1'b0 :
                  (slv_msb ? slv_word[slv_len-1-slv_idx] : slv_word[slv_idx]);

  always @(negedge sck_o) slv_idx <= slv_idx + 1;
  always @(posedge sck_o) cap <= slv_msb ? {cap[30:0], mosi_o} : {mosi_o, cap[31:1]};
  always @(negedge clk) if (sck_o) hi_cnt <= hi_cnt + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic set_slave(input logic [31:0] w, input int len, input bit msb);
    slv_word = w; slv_len = len; slv_msb = msb; slv_idx = 0; cap = '0; hi_cnt = 0;
  endtask

  // Transmit write, then check flag timing (R3, R5), clock high time (R4), receive word.
  task automatic xfer(input logic [31:0] tx, input int n, input int h,
                      input logic [31:0] exp_rx, input string tag);
    logic [31:0] v;
    wr(8'h24, 32'h0000_0200);
    wr(8'h30, tx);
    rd(8'h24, v); chk(v[8] == 1'b0, {tag, " R3 ready cleared on write"}, v, 32'h0);
    @(negedge clk);
    rd(8'h24, v); chk(v[8] == 1'b1, {tag, " R3 ready back after handoff"}, v, 32'h100);
    repeat (2*n*h) @(negedge clk);
    rd(8'h24, v); chk(v[9] == 1'b0, {tag, " R5 full not yet set"}, v, 32'h100);
    @(negedge clk);
    rd(8'h24, v); chk(v[9] == 1'b1, {tag, " R5 full set on due edge"}, v, 32'h300);
    rd(8'h34, v); chk(v == exp_rx, {tag, " R5 receive word"}, v, exp_rx);
    chk(hi_cnt == n*h, {tag, " R4 clock high time"}, hi_cnt, n*h);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h20, v); chk(v == 0, "R1 mode reset", v, 0);
    rd(8'h24, v); chk(v == 32'h100, "R1 status reset", v, 32'h100);
    rd(8'h34, v); chk(v == 0, "R1 receive reset", v, 0);
    chk(!sck_o && !irq_o, "R1 clock and irq low", {sck_o, irq_o}, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); chk(v == 32'h47FF_0000, "R2 mode kept bits", v, 32'h47FF_0000);
    wr(8'h20, 32'h0);
    wr(8'h28, 32'h1234_5678);
    rd(8'h28, v); chk(v == 32'h1234_5678, "R2 mask readback", v, 32'h1234_5678);
    wr(8'h28, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk(v == 0, "R2 reserved low reads 0", v, 0);
    rd(8'h40, v); chk(v == 0, "R2 reserved high reads 0", v, 0);
    rd(8'h30, v); chk(v == 0, "R2 transmit reads 0", v, 0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    int rises = 0;
    wr(8'h30, 32'h0000_00FF);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sck_o) rises++;
    end
    chk(rises == 0, "R10 no clock when disabled", rises, 0);
    rd(8'h24, v); chk(v == 32'h100, "R10 flags untouched", v, 32'h100);
  endtask

  task automatic t_msb8;
    logic [31:0] v;
    wr(8'h20, 32'h0771_0000);
    set_slave(32'hA5, 8, 1'b1);
    xfer(32'hFFFF_FF3C, 8, 4, 32'h0000_00A5, "msb8 R6");
    chk(cap == 32'h3C, "R12 R6 bits sent msb first", cap, 32'h3C);
    wr(8'h28, 32'h200); #0.5; chk(irq_o == 1'b1, "R9 irq from full", irq_o, 1);
    wr(8'h28, 32'h100); #0.5; chk(irq_o == 1'b1, "R9 irq from ready", irq_o, 1);
    wr(8'h28, 32'h0);   #0.5; chk(irq_o == 1'b0, "R9 zero mask quiet", irq_o, 0);
    wr(8'h24, 32'h0000_0000);
    rd(8'h24, v); chk(v == 32'h300, "R8 write zero keeps", v, 32'h300);
    wr(8'h24, 32'h0000_0200);
    rd(8'h24, v); chk(v == 32'h100, "R8 clear full only", v, 32'h100);
    wr(8'h28, 32'h200); #0.5; chk(irq_o == 1'b0, "R9 cleared flag quiet", irq_o, 0);
    wr(8'h28, 32'h0);
  endtask

  task automatic t_lsb12;
    wr(8'h20, 32'h03B2_0000);
    set_slave(32'h9C1, 12, 1'b0);
    xfer(32'hFFFF_F5A3, 12, 8, 32'h0000_09C1, "lsb12 R6");
    chk((cap >> 20) == 32'h5A3, "R6 R5 bits sent lsb first", cap >> 20, 32'h5A3);
  endtask

  task automatic t_loop32;
    wr(8'h20, 32'h4701_0000);
    set_slave(32'hFFFF_FFFF, 32, 1'b1);
    xfer(32'hDEAD_BEEF, 32, 4, 32'hDEAD_BEEF, "loop32 R7");
  endtask

  task automatic t_len4;
    wr(8'h20, 32'h4731_0000);
    set_slave(32'h0, 4, 1'b1);
    xfer(32'h0000_00F6, 4, 4, 32'h6, "code3 R5");
    wr(8'h20, 32'h4711_0000);
    set_slave(32'h0, 4, 1'b1);
    xfer(32'h0000_00F9, 4, 4, 32'h9, "code1 R5");
  endtask

  task automatic t_cmd;
    logic [31:0] v;
    wr(8'h20, 32'h4771_0000);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, v); chk(v == 0, "R11 command reads 0", v, 0);
    rd(8'h20, v); chk(v == 32'h4771_0000, "R11 mode unchanged", v, 32'h4771_0000);
    rd(8'h24, v); chk(v == 32'h300, "R11 status unchanged", v, 32'h300);
    set_slave(32'h0, 8, 1'b1);
    xfer(32'h0000_005A, 8, 4, 32'h5A, "cmd R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_disabled;
    t_msb8;
    t_lsb12;
    t_loop32;
    t_len4;
    t_cmd;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule